// File: doc/BRIEF.md
# Read-Valid Latency Trainer

This block learns, separately for each byte lane of a double-width memory read path, how many system-clock cycles pass between a read command and the cycle on which that lane's captured data is valid. After reset it issues a short training sequence on its own. It writes a two-beat known pattern, issues one read, and then sweeps a cycle counter upward from one. Each lane takes as its latency the first count at which its captured byte equals that lane's byte of the first pattern beat.

Once every lane has a latency, the block raises its ready flag and forwards user read requests to the command output. A shift register of past user reads gives each lane its own enable at its learned latency. Each lane's gated data is then delayed by the difference between the largest learned latency and its own, so that a whole word reaches the output on one cycle, qualified by a single valid strobe. If any lane finds no match by the largest allowed latency, the block stops and raises its error flag.

A read is a burst of four, so it returns two beats on consecutive cycles. User reads must be spaced at least two cycles apart.

Top module: `rden_train`

## Requirements
- R1: While reset is high, `ready`, `err`, `rd_valid`, `wr_en` and `rd_cmd` are all low.
- R2: After reset is released, `wr_en` is high for exactly two cycles, carrying `PAT0` and then `PAT1` on `wr_data`. Exactly one training read is then issued on `rd_cmd`.
- R3: Let the training read be issued in cycle T, and let each lane's latency be the smallest k (1 ≤ k ≤ `MAX_DLY`) at which that lane's byte of `cap_data` in cycle T+k equals its byte of `PAT0`. Let M be the largest of these latencies. Then `ready` rises in cycle T+M+1.
- R4: If some lane has no match for any k up to `MAX_DLY`, `err` rises in cycle T+`MAX_DLY`+1, `ready` stays low, and no further `wr_en` or `rd_cmd` is produced.
- R5: While `ready` is high, `usr_rd` appears on `rd_cmd` in the same cycle. Before `ready`, or after `err`, `usr_rd` is ignored: it gives no command and no valid output.
- R6: A user read in cycle t makes `rd_valid` high in cycles t+M and t+M+1.
- R7: In those two cycles, lane l of `rd_data` (bits l*8+7 down to l*8) carries lane l's `cap_data` byte from cycles t+L(l) and t+L(l)+1, where L(l) is that lane's own latency.
- R8: `rd_data` is all zero whenever `rd_valid` is low.
- R9: `ready` and `err` are never high together. Each stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_rd | input | 1 | User read request |
| cap_data | input | LANES*DW | Captured read data, one byte per lane, in the system clock domain |
| rd_cmd | output | 1 | Read command to the memory |
| wr_en | output | 1 | Training write beat strobe |
| wr_data | output | LANES*DW | Training write pattern beat |
| rd_data | output | LANES*DW | Lane-aligned read data |
| rd_valid | output | 1 | Qualifies `rd_data` |
| ready | output | 1 | Training complete |
| err | output | 1 | Training failed |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of lane timing. These are: the flags are mutually exclusive and sticky, valid appears only when ready, valid pulses come in pairs, training writes happen only before ready, and a command seen after ready always comes from a user request. The bench's scenarios cover the rest. A memory model places each lane's bytes at its own latency, so the bench can show that the latencies learned are correct, that `ready` and `err` rise on the exact cycle, that each word comes out whole at the largest latency, and that deskew works with equal, minimal, maximal and out-of-range lane latencies.

// File: rtl/rden_train.sv
module rden_train #(
  parameter int LANES   = 2,
  parameter int DW      = 8,
  parameter int MAX_DLY = 12,
  parameter logic [LANES*DW-1:0] PAT0 = 16'hA53C,
  parameter logic [LANES*DW-1:0] PAT1 = 16'h5AC3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                usr_rd,
  input  logic [LANES*DW-1:0] cap_data,
  output logic                rd_cmd,
  output logic                wr_en,
  output logic [LANES*DW-1:0] wr_data,
  output logic [LANES*DW-1:0] rd_data,
  output logic                rd_valid,
  output logic                ready,
  output logic                err
);
  localparam int CW = $clog2(MAX_DLY + 2);

  typedef enum logic [2:0] {S_IDLE, S_WR0, S_WR1, S_RD, S_SRCH, S_RDY, S_ERR} st_t;

  st_t              st;
  logic [CW-1:0]    cnt, max_lat;
  logic [CW-1:0]    lat [LANES];
  logic [LANES-1:0] found, hit;
  logic [MAX_DLY:0] hist;
  logic [MAX_DLY+1:0] hx;

  assign ready   = (st == S_RDY);
  assign err     = (st == S_ERR);
  assign wr_en   = (st == S_WR0) || (st == S_WR1);
  assign wr_data = (st == S_WR0) ? PAT0 : (st == S_WR1) ? PAT1 : '0;
  assign rd_cmd  = (st == S_RD) || (ready && usr_rd);

  assign hx = {hist, ready && usr_rd};
  assign rd_valid = ready && (hx[max_lat] || hx[{1'b0, max_lat} + 1'b1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      max_lat <= '0;
      found   <= '0;
      for (int l = 0; l < LANES; l++) lat[l] <= '0;
    end else begin
      case (st)
        S_IDLE: st <= S_WR0;
        S_WR0:  st <= S_WR1;
        S_WR1:  st <= S_RD;
        S_RD: begin
          st  <= S_SRCH;
          cnt <= CW'(1);
        end
        S_SRCH: begin
          for (int l = 0; l < LANES; l++)
            if (!found[l] && hit[l]) begin
              found[l] <= 1'b1;
              lat[l]   <= cnt;
              max_lat  <= cnt;
            end
          if ((found | hit) == '1)      st <= S_RDY;
          else if (cnt == CW'(MAX_DLY)) st <= S_ERR;
          else                          cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[MAX_DLY-1:0], ready && usr_rd};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] din, dout;
    logic [CW-1:0] skew;
    logic [MAX_DLY-1:0][DW-1:0] pipe;

    assign hit[g] = (cap_data[g*DW +: DW] == PAT0[g*DW +: DW]);
    assign din    = (hx[lat[g]] || hx[{1'b0, lat[g]} + 1'b1]) ? cap_data[g*DW +: DW] : '0;
    assign skew   = max_lat - lat[g];

    always_ff @(posedge clk) pipe <= {pipe[MAX_DLY-2:0], din};

    assign dout = (skew == '0) ? din : pipe[skew - 1'b1];
    assign rd_data[g*DW +: DW] = rd_valid ? dout : '0;
  end
endmodule

module rden_train_chk (
  input logic clk,
  input logic rst,
  input logic usr_rd,
  input logic rd_cmd,
  input logic wr_en,
  input logic rd_valid,
  input logic ready,
  input logic err
);
  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ready && err));
  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst) ready |=> ready);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
  // R5
  valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> ready);
  // R6
  valid_pair_chk: assert property (@(posedge clk) disable iff (rst) $rose(rd_valid) |=> rd_valid);
  // R2
  wr_before_ready_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> !ready && !err);
  // R5
  cmd_from_user_chk: assert property (@(posedge clk) disable iff (rst) (ready && rd_cmd) |-> usr_rd);
  // R4
  quiet_after_err_chk: assert property (@(posedge clk) disable iff (rst) err |-> !rd_cmd && !wr_en);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !ready && !err && !rd_valid);
endmodule

bind rden_train rden_train_chk u_chk (
  .clk(clk), .rst(rst), .usr_rd(usr_rd), .rd_cmd(rd_cmd), .wr_en(wr_en),
  .rd_valid(rd_valid), .ready(ready), .err(err)
);

// File: tb/rden_train_tb.sv
module rden_train_tb;
  localparam int CLK_P = 10;
  localparam int MAXD  = 12;
  localparam logic [15:0] P0 = 16'hA53C;
  localparam logic [15:0] P1 = 16'h5AC3;

  logic clk = 0, rst = 1, usr_rd = 0;
  logic [15:0] cap_data, wr_data, rd_data;
  logic rd_cmd, wr_en, rd_valid, ready, err;

  rden_train #(.LANES(2), .DW(8), .MAX_DLY(MAXD), .PAT0(P0), .PAT1(P1)) u_dut (
    .clk(clk), .rst(rst), .usr_rd(usr_rd), .cap_data(cap_data), .rd_cmd(rd_cmd),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready(ready), .err(err));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, trd = 0, ntr = 0, nw = 0, nrd = 0, issued = 0, mlat = 0;
  int lat [2];
  logic [15:0] wb [2];
  logic [7:0] sd [2][64];
  logic       sv [2][64];
  int          q_cyc [$];
  logic [15:0] q_dat [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ud(input int n, input int b, input int l);
    return 8'(8'h40 + n*8 + b*2 + l);
  endfunction

  // memory model
  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < 2; l++) for (int i = 0; i < 64; i++) sv[l][i] <= 1'b0;
      nw <= 0; ntr <= 0; nrd <= 0;
    end else begin
      if (wr_en) begin
        if (nw < 2) wb[nw] <= wr_data;
        nw <= nw + 1;
      end
      for (int l = 0; l < 2; l++) sv[l][cyc % 64] <= 1'b0;
      if (rd_cmd) begin
        if (!ready) begin
          ntr <= ntr + 1;
          trd <= cyc;
        end else nrd <= nrd + 1;
        for (int l = 0; l < 2; l++) begin
          sv[l][(cyc + lat[l]) % 64]     <= 1'b1;
          sv[l][(cyc + lat[l] + 1) % 64] <= 1'b1;
          sd[l][(cyc + lat[l]) % 64]     <= !ready ? wb[0][l*8 +: 8] : ud(nrd + 1, 0, l);
          sd[l][(cyc + lat[l] + 1) % 64] <= !ready ? wb[1][l*8 +: 8] : ud(nrd + 1, 1, l);
        end
      end
    end
    cyc <= cyc + 1;
  end

  always @* begin
    for (int l = 0; l < 2; l++)
      cap_data[l*8 +: 8] = sv[l][cyc % 64] ? sd[l][cyc % 64] : 8'h11;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && ready) begin
      if (rd_valid) begin
        if (q_cyc.size() == 0) chk(0, "R6 unexpected valid", cyc, 0);
        else begin
          int ec;
          logic [15:0] ed;
          ec = q_cyc.pop_front();
          ed = q_dat.pop_front();
          chk(cyc == ec, "R6 valid cycle", cyc, ec);
          chk(rd_data == ed, "R7 aligned data", rd_data, ed);
        end
      end else if (rd_data != 16'h0) chk(0, "R8 data while not valid", rd_data, 0);
    end
  end

  task automatic do_rd(input int gap);
    @(negedge clk);
    usr_rd = 1;
    issued++;
    q_cyc.push_back(cyc + mlat);
    q_dat.push_back({ud(issued, 0, 1), ud(issued, 0, 0)});
    q_cyc.push_back(cyc + mlat + 1);
    q_dat.push_back({ud(issued, 1, 1), ud(issued, 1, 0)});
    @(negedge clk);
    usr_rd = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic train(input int l0, input int l1, input bit expect_ok);
    int w;
    bit rdy_seen;
    lat[0] = l0; lat[1] = l1;
    mlat = (l0 > l1) ? l0 : l1;
    issued = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!ready && !err && !rd_valid && !wr_en && !rd_cmd, "R1 reset outputs",
        {ready, err, rd_valid, wr_en, rd_cmd}, 0);
    rst = 0;
    // R5: requests during training are ignored
    @(negedge clk); usr_rd = 1;
    @(negedge clk); usr_rd = 0;
    w = 0;
    while (!ready && !err && w < 100) begin @(negedge clk); w++; end
    chk(nw == 2 && wb[0] == P0, "R2 write beat0", wb[0], P0);
    chk(wb[1] == P1, "R2 write beat1", wb[1], P1);
    chk(ntr == 1, "R2/R5 one training read", ntr, 1);
    rdy_seen = ready;
    if (expect_ok) begin
      chk(rdy_seen && !err, "R3 ready", {ready, err}, 2);
      chk(cyc == trd + mlat + 1, "R3 ready cycle", cyc, trd + mlat + 1);
    end else begin
      chk(err && !ready, "R4 err", {ready, err}, 1);
      chk(cyc == trd + MAXD + 1, "R4 err cycle", cyc, trd + MAXD + 1);
    end
  endtask

  task automatic drain();
    repeat (mlat + 6) @(negedge clk);
    chk(q_cyc.size() == 0, "R6 all reads returned", q_cyc.size(), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lat[0] = 3; lat[1] = 5;
    // unequal lanes, back-to-back and spaced reads
    train(3, 5, 1);
    do_rd(0); do_rd(0); do_rd(0); do_rd(4); do_rd(7);
    drain();
    // equal lanes
    train(4, 4, 1);
    do_rd(0); do_rd(2); do_rd(0);
    drain();
    // minimum and maximum latency
    train(1, MAXD, 1);
    do_rd(0); do_rd(0); do_rd(9);
    drain();
    // out of range lane: error, then quiet
    train(2, MAXD + 1, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); usr_rd = 1;
      #1 chk(!rd_cmd && !wr_en && !rd_valid, "R4/R5 ignored after error",
             {rd_cmd, wr_en, rd_valid}, 0);
    end
    usr_rd = 0;
    chk(err && !ready, "R9 err sticky", {ready, err}, 1);
    // retrain after error, lane 0 slower
    train(7, 2, 1);
    do_rd(0); do_rd(1); do_rd(0);
    drain();
    chk(ready && !err, "R9 ready sticky", {ready, err}, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule